// File: doc/BRIEF.md
# Byte-Bus Serial Port Register Front End

This block is the software-visible register layer of a classic byte-oriented serial port, with no bit-level line engine behind it. A host reaches eight byte-wide registers over a simple bus (address, write enable, read strobe, write data, registered read data). Received characters come in on a valid/ready byte stream and are popped by reads of the data register. Written characters leave on a byte output with a one-cycle valid strobe. The block keeps the interrupt-enable mask, the line-control and modem-control bytes and two pending flags, and it reports interrupt identification and line status.

Interrupts are not posted when their cause appears. Each source (receive data available, transmit holding empty) owns a delay timer of `IRQ_DELAY` clock cycles. A new request restarts the full delay. When the count runs out, the pending flag is set only if that source is still enabled at that moment. The single level interrupt output is high while either pending flag is set. Bit 7 of the line-control byte switches offsets 0 and 1 to an inert divisor-latch window. A single magic modem-control write loads a fixed loopback signature.

Top module: `serial_reg_front`

## Requirements
- R1: Offsets 0 to 7 are the registers. A read or write with an address of 8 or more raises `bus_err` for one cycle, one cycle after the access. It returns read data 0 and changes no state, and it does not alias onto offsets 0 to 7.
- R2: While line-control bit 7 is set, reads of offsets 0 and 1 return 0, writes there are ignored, and no received byte is popped. The line-control byte (offset 3) reads back what was last written.
- R3: A started timer sets its pending flag at the clock edge exactly `IRQ_DELAY` edges after the starting edge, and only if the matching enable bit is set at expiry. A cancelled timer sets nothing.
- R4: A start request while a timer runs restarts the full delay, measured from the new request.
- R5: The identification register (offset 2) reads 0x04 while receive is pending, otherwise 0x02 while transmit is pending, and otherwise 0x01. Every read of it clears transmit pending.
- R6: A data read (offset 0) returns the offered byte, or 0 when `rx_valid` is low. It pops the byte via `rx_ready` and clears receive pending. If data is still offered on the next cycle with receive enabled (enable bit 0), the receive timer restarts then. A byte newly offered while receive is enabled also starts the receive timer.
- R7: A data write (offset 0) drives `tx_data` with `tx_valid` high for one cycle and clears transmit pending. If transmit is enabled (enable bit 1), it starts the transmit timer.
- R8: Writing the enable register (offset 1) stores the byte for readback. With bit 1 set, the write starts the transmit timer; with bit 1 clear, it cancels that timer and clears transmit pending. With bit 0 set and a byte offered, it starts the receive timer; otherwise it cancels that timer and clears receive pending.
- R9: Line status (offset 5) reads 0x60 with bit 0 set while a byte is offered. Bit 5 is holding-register empty and bit 6 is transmitter empty.
- R10: Offsets 6 and 7 always read 0. Writes to offsets 2, 6 and 7 change nothing that can be read back.
- R11: Writing 0x1A to modem control (offset 4) sets it to 0x9A. Any other write leaves it unchanged, and offset 4 reads it back.
- R12: `irq` is high exactly while a pending flag is set. Reset clears all registers, flags, timers and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| bus_err | output | 1 | Out-of-range access flag, one cycle after the access |
| rx_data | input | 8 | Offered receive byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Pop of the offered byte |
| tx_data | output | 8 | Last transmitted byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions watch the cycle-local rules on every cycle. No pending flag rises without its timer expiring while the source is enabled, and the interrupt never rises without an expiry. An identification read always leaves transmit pending clear, and no pop happens inside the divisor-latch window. `tx_valid` only follows a data write, errors only follow out-of-range addresses, line status always carries its fixed empty bits, and modem control only ever changes to its signature. The exact delay length, restarting on a second request, source priority, re-arming after a pop, and the readback of every register need the bench's sequences, which count cycles against `IRQ_DELAY`.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int OFS_W   = 3;
  localparam int NREGS   = 1 << OFS_W;
  localparam int NSRC    = 2;
  localparam int SRC_RX  = 0;   // also the enable-register bit of the source
  localparam int SRC_TX  = 1;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IID  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTS = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTS = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR  = 3'd7;

  localparam int          LCTL_WIN_BIT = 7;
  localparam logic [7:0]  MCTL_MAGIC   = 8'h1A;
  localparam logic [7:0]  MCTL_SIG     = 8'h9A;
  localparam logic [7:0]  IID_RX       = 8'h04;
  localparam logic [7:0]  IID_TX       = 8'h02;
  localparam logic [7:0]  IID_NONE     = 8'h01;

  typedef struct packed {
    logic start;
    logic cancel;
  } tmr_cmd_t;

  function automatic logic [7:0] iid_code(input logic rx_p, input logic tx_p);
    if (rx_p)      return IID_RX;
    else if (tx_p) return IID_TX;
    else           return IID_NONE;
  endfunction

  function automatic logic [7:0] lsts_value(input logic avail);
    return {1'b0, 1'b1, 1'b1, 4'b0000, avail};
  endfunction
endpackage

// File: rtl/srf_delay_timer.sv
module srf_delay_timer #(
  parameter int DELAY = 450
) (
  input  logic clk,
  input  logic rst_n,
  input  srf_pkg::tmr_cmd_t cmd,
  output logic running,
  output logic expire
);
  localparam int CNT_W = $clog2(DELAY + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cmd.start)    cnt_q <= CNT_W'(DELAY);
    else if (cmd.cancel)   cnt_q <= '0;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign running = (cnt_q != '0);
  assign expire  = (cnt_q == CNT_W'(1)) && !cmd.start && !cmd.cancel;
endmodule

// File: rtl/srf_pend_flags.sv
module srf_pend_flags #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] expire,
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] clear,
  output logic [NSRC-1:0] pend
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)                        pend[s] <= 1'b0;
      else if (clear[s])                 pend[s] <= 1'b0;
      else if (expire[s] && enable[s])   pend[s] <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front #(
  parameter int ADDR_W    = 4,
  parameter int IRQ_DELAY = 450
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_err,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              irq
);
  import srf_pkg::*;

  logic [7:0] ien_q, lctl_q, mctl_q;
  logic [7:0] rdata_q, txd_q;
  logic       err_q, txv_q, avail_q, pop_q;

  // decode
  logic             in_range, win, acc;
  logic [OFS_W-1:0] ofs;
  if (ADDR_W > OFS_W) begin : g_wide
    assign in_range = (bus_addr[ADDR_W-1:OFS_W] == '0);
  end else begin : g_narrow
    assign in_range = 1'b1;
  end
  assign ofs = bus_addr[OFS_W-1:0];
  assign win = lctl_q[LCTL_WIN_BIT];
  assign acc = bus_rd || bus_wr;

  // named internal events
  logic dat_rd, dat_wr, ien_wr, iid_rd, lctl_wr, mctl_wr, rx_arrive;
  assign dat_rd    = bus_rd && in_range && (ofs == OFS_DATA) && !win;
  assign dat_wr    = bus_wr && in_range && (ofs == OFS_DATA) && !win;
  assign ien_wr    = bus_wr && in_range && (ofs == OFS_IEN)  && !win;
  assign iid_rd    = bus_rd && in_range && (ofs == OFS_IID);
  assign lctl_wr   = bus_wr && in_range && (ofs == OFS_LCTL);
  assign mctl_wr   = bus_wr && in_range && (ofs == OFS_MCTL);
  assign rx_arrive = rx_valid && !avail_q;

  // timer commands
  tmr_cmd_t  cmd [NSRC];
  logic [NSRC-1:0] tmr_start, tmr_cancel, tmr_expire, tmr_run, pend_clr, pend;

  always_comb begin
    tmr_start  = '0;
    tmr_cancel = '0;
    if (ien_wr) begin
      tmr_start[SRC_TX]  = bus_wdata[SRC_TX];
      tmr_cancel[SRC_TX] = !bus_wdata[SRC_TX];
      tmr_start[SRC_RX]  = bus_wdata[SRC_RX] && rx_valid;
      tmr_cancel[SRC_RX] = !(bus_wdata[SRC_RX] && rx_valid);
    end else begin
      tmr_start[SRC_TX]  = dat_wr && ien_q[SRC_TX];
      tmr_start[SRC_RX]  = ien_q[SRC_RX] && rx_valid && (rx_arrive || pop_q);
    end
    pend_clr         = tmr_cancel;
    pend_clr[SRC_TX] = pend_clr[SRC_TX] || dat_wr || iid_rd;
    pend_clr[SRC_RX] = pend_clr[SRC_RX] || dat_rd;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_tmr
    assign cmd[s] = '{start: tmr_start[s], cancel: tmr_cancel[s]};
    srf_delay_timer #(.DELAY(IRQ_DELAY)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd[s]),
      .running (tmr_run[s]),
      .expire  (tmr_expire[s])
    );
  end

  srf_pend_flags #(.NSRC(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (tmr_expire),
    .enable (ien_q[NSRC-1:0]),
    .clear  (pend_clr),
    .pend   (pend)
  );

  // read mux
  logic [7:0] rd_val;
  always_comb begin
    rd_val = 8'h00;
    if (in_range) begin
      case (ofs)
        OFS_DATA: rd_val = (win || !rx_valid) ? 8'h00 : rx_data;
        OFS_IEN:  rd_val = win ? 8'h00 : ien_q;
        OFS_IID:  rd_val = iid_code(pend[SRC_RX], pend[SRC_TX]);
        OFS_LCTL: rd_val = lctl_q;
        OFS_MCTL: rd_val = mctl_q;
        OFS_LSTS: rd_val = lsts_value(rx_valid);
        default:  rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q   <= '0;
      lctl_q  <= '0;
      mctl_q  <= '0;
      rdata_q <= '0;
      txd_q   <= '0;
      err_q   <= 1'b0;
      txv_q   <= 1'b0;
      avail_q <= 1'b0;
      pop_q   <= 1'b0;
    end else begin
      rdata_q <= bus_rd ? rd_val : 8'h00;
      err_q   <= acc && !in_range;
      txv_q   <= dat_wr;
      avail_q <= rx_valid;
      pop_q   <= dat_rd;
      if (dat_wr)  txd_q  <= bus_wdata;
      if (ien_wr)  ien_q  <= bus_wdata;
      if (lctl_wr) lctl_q <= bus_wdata;
      if (mctl_wr && (bus_wdata == MCTL_MAGIC)) mctl_q <= MCTL_SIG;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign rx_ready  = dat_rd;
  assign tx_data   = txd_q;
  assign tx_valid  = txv_q;
  assign irq       = |pend;
endmodule

// File: rtl/serial_reg_front_chk.sv
module serial_reg_front_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              bus_err,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic [7:0]        lctl_q,
  input logic [7:0]        mctl_q,
  input logic [7:0]        ien_q,
  input logic [1:0]        pend,
  input logic [1:0]        tmr_expire,
  input logic              iid_rd
);
  AST_ERR_FROM_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past((bus_rd || bus_wr) && (int'(bus_addr) > 7))); // R1
  AST_WIN_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == '0) && lctl_q[7]) |-> !rx_ready); // R2
  AST_TXP_NEEDS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> $past(tmr_expire[1] && ien_q[1])); // R3
  AST_RXP_NEEDS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(tmr_expire[0] && ien_q[0])); // R3
  AST_IID_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $past(iid_rd) |-> !pend[1]); // R5
  AST_TXV_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && (bus_addr == '0) && !lctl_q[7])); // R7
  AST_LSTS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (int'(bus_addr) == 5)) |-> (bus_rdata[6:5] == 2'b11)); // R9
  AST_MCTL_SIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mctl_q) |-> (mctl_q == 8'h9A)); // R11
  AST_IRQ_RISE_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|tmr_expire)); // R12
endmodule

bind serial_reg_front serial_reg_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .irq        (irq),
  .lctl_q     (lctl_q),
  .mctl_q     (mctl_q),
  .ien_q      (ien_q),
  .pend       (pend),
  .tmr_expire (tmr_expire),
  .iid_rd     (iid_rd)
);

// File: tb/serial_reg_front_tb_top.sv
module serial_reg_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int D          = 12;
  localparam int WDOG       = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata, tx_data, rx_data = '0;
  logic              bus_err, rx_valid = 1'b0, rx_ready, tx_valid, irq;

  int checks = 0, fails = 0, pops = 0;

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) if (rst_n && rx_ready && rx_valid) pops <= pops + 1;

  serial_reg_front #(.ADDR_W(ADDR_W), .IRQ_DELAY(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq));

  // {is_read, addr, data, expected, requirement number}
  localparam int NV = 26;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 4'd3, 8'h00, 8'h00, 8'd12},  // R12 line control after reset
    {1'b1, 4'd1, 8'h00, 8'h00, 8'd12},  // R12 enable after reset
    {1'b1, 4'd4, 8'h00, 8'h00, 8'd12},  // R12 modem control after reset
    {1'b1, 4'd2, 8'h00, 8'h01, 8'd5},   // R5 nothing pending
    {1'b1, 4'd5, 8'h00, 8'h60, 8'd9},   // R9 no byte offered
    {1'b0, 4'd3, 8'h03, 8'h00, 8'd2},
    {1'b1, 4'd3, 8'h00, 8'h03, 8'd2},   // R2 line control readback
    {1'b0, 4'd7, 8'h5A, 8'h00, 8'd10},
    {1'b1, 4'd7, 8'h00, 8'h00, 8'd10},  // R10 scratch reads zero
    {1'b1, 4'd6, 8'h00, 8'h00, 8'd10},  // R10 modem status zero
    {1'b0, 4'd2, 8'hC7, 8'h00, 8'd10},
    {1'b1, 4'd2, 8'h00, 8'h01, 8'd10},  // R10 FIFO write ignored
    {1'b0, 4'd4, 8'h13, 8'h00, 8'd11},
    {1'b1, 4'd4, 8'h00, 8'h00, 8'd11},  // R11 non-magic ignored
    {1'b0, 4'd4, 8'h1A, 8'h00, 8'd11},
    {1'b1, 4'd4, 8'h00, 8'h9A, 8'd11},  // R11 signature loaded
    {1'b0, 4'd4, 8'h00, 8'h00, 8'd11},
    {1'b1, 4'd4, 8'h00, 8'h9A, 8'd11},  // R11 unchanged
    {1'b0, 4'd3, 8'h80, 8'h00, 8'd2},
    {1'b0, 4'd1, 8'h03, 8'h00, 8'd2},
    {1'b1, 4'd1, 8'h00, 8'h00, 8'd2},   // R2 window reads zero
    {1'b0, 4'd3, 8'h00, 8'h00, 8'd2},
    {1'b1, 4'd1, 8'h00, 8'h00, 8'd2},   // R2 window write ignored
    {1'b0, 4'd1, 8'hF0, 8'h00, 8'd8},
    {1'b1, 4'd1, 8'h00, 8'hF0, 8'd8},   // R8 enable readback
    {1'b0, 4'd1, 8'h00, 8'h00, 8'd8}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = '0;
    d = bus_rdata;
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    int p0;
    tick(3);
    check("R12 irq in reset", irq, 0);
    check("R12 tx_valid in reset", tx_valid, 0);
    rst_n = 1'b1;
    tick(1);
    check("R12 bus_err after reset", bus_err, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        rd_reg(VEC[i][27:24], r);
        check($sformatf("R%0d vector %0d", VEC[i][7:0], i), r, VEC[i][15:8]);
      end else begin
        wr_reg(VEC[i][27:24], VEC[i][23:16]);
      end
    end

    // R1 out-of-range accesses
    rd_reg(4'd9, r);
    check("R1 oor read data", r, 0);
    check("R1 oor read err", bus_err, 1);
    wr_reg(4'd11, 8'h83);
    check("R1 oor write err", bus_err, 1);
    wr_reg(4'd8, 8'h44);
    check("R1 no alias onto data", tx_valid, 0);
    rd_reg(4'd3, r);
    check("R1 line control untouched", r, 8'h00);
    check("R1 err drops", bus_err, 0);

    // R7 data write without transmit enable
    wr_reg(4'd0, 8'hA5);
    check("R7 tx_valid", tx_valid, 1);
    check("R7 tx_data", tx_data, 8'hA5);
    tick(1);
    check("R7 tx_valid single cycle", tx_valid, 0);
    tick(D + 2);
    check("R7 no timer when disabled", irq, 0);

    // R3 / R8 transmit enable starts the delay
    wr_reg(4'd1, 8'h02);
    tick(D - 1);
    check("R3 not before delay", irq, 0);
    tick(1);
    check("R3 at delay", irq, 1);
    rd_reg(4'd2, r);
    check("R5 transmit code", r, 8'h02);
    check("R5 read clears transmit", irq, 0);

    // R4 restart by a data write
    wr_reg(4'd1, 8'h02);
    tick(4);
    wr_reg(4'd0, 8'h3E);
    tick(D - 1);
    check("R4 old deadline ignored", irq, 0);
    tick(1);
    check("R4 new deadline", irq, 1);
    wr_reg(4'd1, 8'h00);
    check("R8 disable clears transmit", irq, 0);

    // R3 cancel before expiry
    wr_reg(4'd1, 8'h02);
    tick(3);
    wr_reg(4'd1, 8'h00);
    tick(D + 2);
    check("R3 cancelled timer silent", irq, 0);

    // R5 / R6 priority and receive path
    @(negedge clk); rx_data = 8'h3C; rx_valid = 1'b1;
    tick(2);
    wr_reg(4'd1, 8'h03);
    tick(D);
    check("R8 both pending", irq, 1);
    rd_reg(4'd2, r);
    check("R5 receive outranks", r, 8'h04);
    rd_reg(4'd2, r);
    check("R5 receive still reported", r, 8'h04);
    p0 = pops;
    rd_reg(4'd0, r);
    check("R6 popped byte", r, 8'h3C);
    check("R6 one pop", pops - p0, 1);
    check("R6 read clears receive", irq, 0);
    tick(D);
    check("R6 re-arm not early", irq, 0);
    tick(1);
    check("R6 re-armed after pop", irq, 1);
    rd_reg(4'd5, r);
    check("R9 data ready set", r, 8'h61);
    wr_reg(4'd1, 8'h00);
    check("R8 disable clears receive", irq, 0);
    @(negedge clk); rx_valid = 1'b0;
    rd_reg(4'd0, r);
    check("R6 empty read", r, 8'h00);

    // R6 arrival starts the receive timer
    wr_reg(4'd1, 8'h01);
    tick(D + 2);
    check("R8 no receive start without data", irq, 0);
    @(negedge clk); rx_data = 8'h77; rx_valid = 1'b1;
    tick(D);
    check("R6 arrival not early", irq, 0);
    tick(1);
    check("R6 arrival posts", irq, 1);

    // R2 window blocks pop and transmit
    wr_reg(4'd3, 8'h80);
    p0 = pops;
    rd_reg(4'd0, r);
    check("R2 window data read zero", r, 0);
    check("R2 window no pop", pops - p0, 0);
    check("R2 receive still pending", irq, 1);
    wr_reg(4'd0, 8'h55);
    check("R2 window no transmit", tx_valid, 0);
    wr_reg(4'd3, 8'h00);
    rd_reg(4'd0, r);
    check("R6 byte after window", r, 8'h77);
    check("R6 pop after window", pops - p0, 1);
    wr_reg(4'd1, 8'h00);
    @(negedge clk); rx_valid = 1'b0;

    // R12 reset mid-operation
    wr_reg(4'd3, 8'h1B);
    wr_reg(4'd1, 8'h02);
    tick(D);
    check("R12 irq before reset", irq, 1);
    @(negedge clk); rst_n = 1'b0;
    tick(2);
    check("R12 irq cleared by reset", irq, 0);
    rst_n = 1'b1;
    rd_reg(4'd3, r);
    check("R12 line control cleared", r, 0);
    rd_reg(4'd4, r);
    check("R12 modem control cleared", r, 0);
    rd_reg(4'd1, r);
    check("R12 enable cleared", r, 0);
    tick(D + 2);
    check("R12 timer cleared", irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule